// File: doc/BRIEF.md
# Multi-Cycle Datapath with Shared Memory Port

This block is the datapath half of a 32-bit processor that runs each instruction over several clock cycles. One memory port serves both instruction fetches and data accesses, and one ALU handles every computation. Those two resources are shared across cycles through widened selectors. Values that must survive into a later cycle of the same instruction are held in registers: the program counter, the instruction register, a memory data register, two operand latches and an ALU result register. A 32-entry, 32-bit register file has two read ports and one write port.

An external sequencer drives one strobe or select per control point each cycle. It receives the current opcode back so that it can choose its next step. Memory sits outside the block. The block shows it an address and write data, and it returns read data combinationally.

Top module: `mc_datapath`

## Requirements
- R1: While rst_n is low, every internal register and every register-file entry is zero. The first address shown after reset is 0, write data is 0 and the opcode is 0.
- R2: When addr_sel is 0, mem_addr shows the program counter; when it is 1, it shows the ALU result register. mem_wdata always shows operand latch B. The mem_rd_en and mem_wr_en outputs copy rd_req and wr_req.
- R3: The instruction register takes mem_rdata at a clock edge only when ir_load is 1. At other edges it holds its value. opcode always shows its bits 31:26.
- R4: At every clock edge, latch A takes the register addressed by instruction bits 25:21 and latch B takes the register addressed by bits 20:16. At the same edge the memory data register takes mem_rdata and the ALU result register takes the live ALU output.
- R5: The first ALU operand is the program counter when a_src is 0 and latch A when a_src is 1.
- R6: b_src picks the second ALU operand: 00 is latch B, 01 is the constant 4, 10 is instruction bits 15:0 sign-extended, and 11 is that sign-extended value shifted left by two.
- R7: alu_mode 00 adds, 01 subtracts (first minus second), and 11 adds. With 10, instruction bits 5:0 pick the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed less-than giving 1 or 0. Any other code gives 0.
- R8: pc_src picks the next program counter value: 00 is the live ALU output, 01 is the ALU result register, 10 is {PC[31:28], IR[25:0], 2'b00}, and 11 is the live ALU output.
- R9: The program counter is written when pc_we is 1, or when pc_we_zero is 1 and the live ALU output is zero. Otherwise it holds.
- R10: When rf_we is 1, one register-file entry is written at the clock edge. dst_sel 0 addresses it with instruction bits 20:16 and dst_sel 1 with bits 15:11. wb_sel 0 writes the ALU result register and wb_sel 1 writes the memory data register. Reads in the same cycle see the old contents.
- R11: Register 0 always reads as zero, and writes addressed to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Memory byte address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data (latch B) |
| mem_rdata | input | 32 | Memory read data, combinational |
| addr_sel | input | 1 | Address source: 0 program counter, 1 ALU result register |
| rd_req | input | 1 | Read request passed to memory |
| wr_req | input | 1 | Write request passed to memory |
| ir_load | input | 1 | Load the instruction register |
| dst_sel | input | 1 | Write register field: 0 bits 20:16, 1 bits 15:11 |
| rf_we | input | 1 | Register-file write enable |
| wb_sel | input | 1 | Write-back source: 0 ALU result register, 1 memory data register |
| a_src | input | 1 | First ALU operand: 0 program counter, 1 latch A |
| b_src | input | 2 | Second ALU operand select |
| alu_mode | input | 2 | ALU operation mode |
| pc_we | input | 1 | Unconditional program counter write |
| pc_we_zero | input | 1 | Program counter write when the ALU output is zero |
| pc_src | input | 2 | Program counter source select |
| opcode | output | 6 | Instruction register bits 31:26 |

## Verification
The bench drives the control sequences an external sequencer would issue for a short program: two loads, each function code including an unknown one, a store followed by a load from the same word, a branch that falls through, a branch that is taken, and a jump. Operand signs are mixed so that signed less-than gives both 1 and 0 and AND and OR are distinguishable. A write aimed at register 0 and a store of register 0 show whether that entry stays zero. Extra cycles exercise the fallback ALU mode and PC source codes, and a run with the instruction register disabled shows whether it holds while the fetch address moves on.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;
    localparam int unsigned DW  = 32;
    localparam int unsigned RAW = 5;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_SLT,
        OP_NIL
    } alu_fn_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] mdr;
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
        logic [DW-1:0] res;
    } dp_regs_t;
endpackage

// File: rtl/mc_alu_ctl.sv
module mc_alu_ctl
    import mc_dp_pkg::*;
(
    input  logic [1:0] alu_mode,
    input  logic [5:0] fn_code,
    output alu_fn_e    alu_op
);
    always_comb begin
        unique case (alu_mode)
            2'b00:   alu_op = OP_ADD;
            2'b01:   alu_op = OP_SUB;
            2'b10: begin
                unique case (fn_code)
                    FN_ADD:  alu_op = OP_ADD;
                    FN_SUB:  alu_op = OP_SUB;
                    FN_AND:  alu_op = OP_AND;
                    FN_OR:   alu_op = OP_OR;
                    FN_SLT:  alu_op = OP_SLT;
                    default: alu_op = OP_NIL;
                endcase
            end
            default: alu_op = OP_ADD;
        endcase
    end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_dp_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  alu_fn_e        alu_op,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [W-1:0]   res,
    output logic           zero
);
    logic [W-1:0] diff;

    always_comb begin
        diff = x - y;
        unique case (alu_op)
            OP_ADD:  res = x + y;
            OP_SUB:  res = diff;
            OP_AND:  res = x & y;
            OP_OR:   res = x | y;
            OP_SLT:  res = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
            default: res = '0;
        endcase
        zero = (res == '0);
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    localparam int unsigned N = 1 << AW;

    logic [W-1:0] view [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        localparam bit WRITABLE = (i != 0);
        logic [W-1:0] ent_d;
        logic [W-1:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && WRITABLE && (wa == AW'(i)))
                ent_d = wd;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign view[i] = ent_q;
    end

    assign rd1 = view[ra1];
    assign rd2 = view[ra2];

    // R11
    always_comb begin
        if (rst_n && (ra1 == '0)) begin
            zero_reg_chk: assert (rd1 == '0);
        end
    end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_dp_pkg::*;
#(
    parameter int unsigned RF_AW = RAW
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          addr_sel,
    input  logic          rd_req,
    input  logic          wr_req,
    input  logic          ir_load,
    input  logic          dst_sel,
    input  logic          rf_we,
    input  logic          wb_sel,
    input  logic          a_src,
    input  logic [1:0]    b_src,
    input  logic [1:0]    alu_mode,
    input  logic          pc_we,
    input  logic          pc_we_zero,
    input  logic [1:0]    pc_src,
    output logic [5:0]    opcode
);
    localparam int unsigned IMMW = 16;

    dp_regs_t st_d, st_q;

    logic [DW-1:0]    imm_ext;
    logic [DW-1:0]    alu_x, alu_y, alu_res, pc_next, rf_wd;
    logic             alu_zero;
    logic [RF_AW-1:0] rf_wa;
    logic [DW-1:0]    rf_rd1, rf_rd2;
    alu_fn_e          alu_op;

    always_comb begin
        imm_ext = {{(DW-IMMW){st_q.ir[IMMW-1]}}, st_q.ir[IMMW-1:0]};
        alu_x   = a_src ? st_q.opa : st_q.pc;
        unique case (b_src)
            2'b00:   alu_y = st_q.opb;
            2'b01:   alu_y = DW'(4);
            2'b10:   alu_y = imm_ext;
            default: alu_y = imm_ext << 2;
        endcase
        unique case (pc_src)
            2'b01:   pc_next = st_q.res;
            2'b10:   pc_next = {st_q.pc[DW-1:DW-4], st_q.ir[25:0], 2'b00};
            default: pc_next = alu_res;
        endcase
        rf_wa = dst_sel ? st_q.ir[15:11] : st_q.ir[20:16];
        rf_wd = wb_sel ? st_q.mdr : st_q.res;
    end

    mc_alu_ctl u_alu_ctl (
        .alu_mode (alu_mode),
        .fn_code  (st_q.ir[5:0]),
        .alu_op   (alu_op)
    );

    mc_alu #(.W(DW)) u_alu (
        .alu_op (alu_op),
        .x      (alu_x),
        .y      (alu_y),
        .res    (alu_res),
        .zero   (alu_zero)
    );

    mc_regfile #(.W(DW), .AW(RF_AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (st_q.ir[25:21]),
        .ra2   (st_q.ir[20:16]),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    always_comb begin
        st_d     = st_q;
        st_d.mdr = mem_rdata;
        st_d.opa = rf_rd1;
        st_d.opb = rf_rd2;
        st_d.res = alu_res;
        if (ir_load)
            st_d.ir = mem_rdata;
        if (pc_we || (pc_we_zero && alu_zero))
            st_d.pc = pc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr  = addr_sel ? st_q.res : st_q.pc;
    assign mem_wdata = st_q.opb;
    assign mem_rd_en = rd_req;
    assign mem_wr_en = wr_req;
    assign opcode    = st_q.ir[31:26];

    // R3
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_load |=> $stable(st_q.ir));

    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_we && !pc_we_zero) |=> $stable(st_q.pc));

    // R9
    pc_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_we && pc_we_zero && !alu_zero) |=> $stable(st_q.pc));
endmodule

// File: tb/mc_datapath_tb_top.sv
`timescale 1ns/1ps
module mc_datapath_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd_en, mem_wr_en;
    logic        addr_sel = 0, rd_req = 0, wr_req = 0, ir_load = 0, dst_sel = 0;
    logic        rf_we = 0, wb_sel = 0, a_src = 0, pc_we = 0, pc_we_zero = 0;
    logic [1:0]  b_src = 0, alu_mode = 0, pc_src = 0;
    logic [5:0]  opcode;

    int n_chk = 0;
    int n_err = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    logic [31:0] mem [64];
    assign mem_rdata = mem[mem_addr[7:2]];
    always @(posedge clk) if (mem_wr_en) mem[mem_addr[7:2]] <= mem_wdata;

    mc_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .addr_sel(addr_sel), .rd_req(rd_req), .wr_req(wr_req), .ir_load(ir_load),
        .dst_sel(dst_sel), .rf_we(rf_we), .wb_sel(wb_sel), .a_src(a_src),
        .b_src(b_src), .alu_mode(alu_mode), .pc_we(pc_we), .pc_we_zero(pc_we_zero),
        .pc_src(pc_src), .opcode(opcode)
    );

    // Reference model state
    logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_alu;
    logic [31:0] m_rf [32];
    logic [31:0] t_imm, t_x, t_y, t_r, t_addr, t_rd, t_ra, t_rb, t_pn;
    logic [4:0]  t_wa;

    function automatic logic [31:0] ref_alu(input logic [1:0] mode, input logic [5:0] fn,
                                            input logic [31:0] x, input logic [31:0] y);
        if (mode == 2'b01) return x - y;
        if (mode != 2'b10) return x + y;
        case (fn)
            6'h20:   return x + y;
            6'h22:   return x - y;
            6'h24:   return x & y;
            6'h25:   return x | y;
            6'h2A:   return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_ir = 0; m_mdr = 0; m_a = 0; m_b = 0; m_alu = 0;
            for (int i = 0; i < 32; i++) m_rf[i] = 0;
        end else begin
            t_imm = {{16{m_ir[15]}}, m_ir[15:0]};
            t_x   = a_src ? m_a : m_pc;
            case (b_src)
                2'd0: t_y = m_b;
                2'd1: t_y = 32'd4;
                2'd2: t_y = t_imm;
                default: t_y = t_imm * 4;
            endcase
            t_r    = ref_alu(alu_mode, m_ir[5:0], t_x, t_y);
            t_addr = addr_sel ? m_alu : m_pc;
            t_rd   = mem[t_addr[7:2]];
            t_ra   = m_rf[m_ir[25:21]];
            t_rb   = m_rf[m_ir[20:16]];
            t_wa   = dst_sel ? m_ir[15:11] : m_ir[20:16];
            case (pc_src)
                2'd1: t_pn = m_alu;
                2'd2: t_pn = {m_pc[31:28], m_ir[25:0], 2'b00};
                default: t_pn = t_r;
            endcase
            if (rf_we && t_wa != 0) m_rf[t_wa] = wb_sel ? m_mdr : m_alu;
            if (pc_we || (pc_we_zero && t_r == 0)) m_pc = t_pn;
            if (ir_load) m_ir = t_rd;
            m_mdr = t_rd; m_a = t_ra; m_b = t_rb; m_alu = t_r;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("mem_addr", mem_addr, addr_sel ? m_alu : m_pc);
        chk("mem_wdata", mem_wdata, m_b);
        chk("opcode", {26'd0, opcode}, {26'd0, m_ir[31:26]});
        chk("strobes", {30'd0, mem_rd_en, mem_wr_en}, {30'd0, rd_req, wr_req});
    endtask

    // One cycle: check results of the previous step, then apply new controls
    task automatic step(input logic as, input logic rd, input logic wr, input logic irl,
                        input logic ds, input logic rfw, input logic wb, input logic asr,
                        input logic [1:0] bs, input logic [1:0] md, input logic pw,
                        input logic pz, input logic [1:0] ps, input string tag);
        @(negedge clk);
        compare();
        addr_sel = as; rd_req = rd; wr_req = wr; ir_load = irl; dst_sel = ds;
        rf_we = rfw; wb_sel = wb; a_src = asr; b_src = bs; alu_mode = md;
        pc_we = pw; pc_we_zero = pz; pc_src = ps;
        cur_tag = tag;
    endtask

    task automatic fetch();  step(0,1,0,1, 0,0,0, 0,2'd1,2'd0, 1,0,2'd0, "R3"); endtask
    task automatic decode(); step(1,0,0,0, 0,0,0, 0,2'd3,2'd0, 0,0,2'd0, "R5"); endtask
    task automatic run_lw();
        fetch(); decode();
        step(1,0,0,0, 0,0,0, 1,2'd2,2'd0, 0,0,2'd0, "R6");
        step(1,1,0,0, 0,0,0, 0,2'd0,2'd0, 0,0,2'd0, "R2");
        step(0,0,0,0, 0,1,1, 0,2'd0,2'd0, 0,0,2'd0, "R10");
    endtask
    task automatic run_r(input string wb_tag);
        fetch(); decode();
        step(1,0,0,0, 0,0,0, 1,2'd0,2'd2, 0,0,2'd0, "R7");
        step(0,0,0,0, 1,1,0, 0,2'd0,2'd0, 0,0,2'd0, wb_tag);
    endtask
    task automatic run_sw();
        fetch(); decode();
        step(1,0,0,0, 0,0,0, 1,2'd2,2'd0, 0,0,2'd0, "R6");
        step(1,0,1,0, 0,0,0, 0,2'd0,2'd0, 0,0,2'd0, "R4");
    endtask
    task automatic run_beq();
        fetch(); decode();
        step(1,0,0,0, 0,0,0, 1,2'd0,2'd1, 0,1,2'd1, "R9");
    endtask

    function automatic logic [31:0] r_ins(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] <= 32'd0;
        mem[0]  <= i_ins(6'h23, 0, 1, 16'h0080);
        mem[1]  <= i_ins(6'h23, 0, 2, 16'h0084);
        mem[2]  <= r_ins(1, 2, 3, 6'h20);
        mem[3]  <= r_ins(1, 2, 4, 6'h22);
        mem[4]  <= r_ins(1, 2, 5, 6'h24);
        mem[5]  <= r_ins(1, 2, 6, 6'h25);
        mem[6]  <= r_ins(2, 1, 7, 6'h2A);
        mem[7]  <= r_ins(1, 2, 8, 6'h2A);
        mem[8]  <= r_ins(1, 1, 0, 6'h20);
        mem[9]  <= r_ins(1, 2, 10, 6'h3F);
        mem[10] <= i_ins(6'h2B, 0, 3, 16'h0088);
        mem[11] <= i_ins(6'h23, 0, 9, 16'h0088);
        mem[12] <= i_ins(6'h04, 1, 2, 16'h0005);
        mem[13] <= i_ins(6'h04, 3, 3, 16'h0002);
        mem[16] <= {6'h02, 26'd20};
        mem[20] <= i_ins(6'h2B, 0, 0, 16'h008C);
        mem[21] <= r_ins(9, 10, 11, 6'h25);
        mem[32] <= 32'h0000_0007;
        mem[33] <= 32'hFFFF_FFFB;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R1";
        // R1: reset state seen at the ports
        chk("reset addr", mem_addr, 32'd0);
        chk("reset wdata", mem_wdata, 32'd0);
        chk("reset opcode", {26'd0, opcode}, 32'd0);
        run_lw(); run_lw();
        run_r("R10"); run_r("R10"); run_r("R10"); run_r("R10");
        run_r("R7"); run_r("R7");
        run_r("R11");              // write aimed at register 0
        run_r("R7");               // unknown function code
        run_sw(); run_lw();        // store then reload same word
        run_beq();                 // not taken
        run_beq();                 // taken
        fetch(); decode();
        step(0,0,0,0, 0,0,0, 0,2'd0,2'd0, 1,0,2'd2, "R8");   // jump
        run_sw();                  // stores register 0 (R11)
        // R11: B shows register 0 as zero
        step(0,0,0,0, 0,0,0, 0,2'd0,2'd0, 0,0,2'd0, "R11");
        fetch(); decode();
        step(1,0,0,0, 0,0,0, 1,2'd1,2'd3, 0,0,2'd0, "R7");   // mode 11 adds A+4
        step(0,0,0,0, 0,0,0, 0,2'd1,2'd0, 1,0,2'd3, "R8");   // pc_src 11
        // R3: IR held while fetch address moves
        step(0,1,0,0, 0,0,0, 0,2'd1,2'd0, 1,0,2'd0, "R3");
        step(0,1,0,0, 0,0,0, 0,2'd1,2'd0, 1,0,2'd0, "R3");
        step(0,0,0,0, 0,0,0, 0,2'd0,2'd0, 0,0,2'd0, "R9");
        @(negedge clk);
        compare();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule